// File: doc/BRIEF.md
# Atomic Bus Lock Controller

This block watches the stream of bus accesses and grants one master exclusive use of the bus for an atomic sequence. Each memory bank has a 2-bit atomic mode. In read-after-write mode, a write to the bank takes the lock for the master that wrote it. In write-after-read mode, a read takes the lock for the master that read. The lock ends when the same master makes the opposite kind of access to the same bank. If that never happens, a fixed 256-cycle watchdog forces the lock off.

The block reports three things: whether a lock is active, which master holds it, and a one-cycle pulse when the watchdog ends a lock. It also raises a one-cycle flag when another master is blocked, and another when an access hits a bank with the reserved mode. The arbiter that acts on the lock sits outside this block. Every output is registered, so an access seen at clock edge E shows up on the outputs just after E.

Top module: `atomic_lock_ctrl`

## Requirements
- R1: After synchronous reset, all outputs are 0: `lock_active`, `lock_owner`, `timeout_pulse`, `acc_blocked` and `mode_error`.
- R2: Bank b's mode is `bank_mode[2b+1:2b]`. With no lock held, a valid write to a mode-01 bank sets `lock_active` and makes `lock_owner` that master's ID, visible after the sampling edge.
- R3: A mode-01 lock is released when the holding master reads the same bank. `lock_active` is 0 after that edge and `timeout_pulse` stays 0.
- R4: With no lock held, a valid read to a mode-10 bank takes the lock for that master. A write from the same master to the same bank releases it.
- R5: Accesses to a mode-00 bank never take or release the lock.
- R6: A mode-11 access has no effect on the lock, just like mode 00. It raises `mode_error` for exactly the one cycle after the access.
- R7: While a lock is held, an access from any other master neither releases nor re-takes the lock. It raises `acc_blocked` for the one cycle after the access.
- R8: While the lock is held, a locking-type access from the holding master keeps the lock and does not restart the watchdog.
- R9: If a lock is not released, it stays active for exactly 256 cycles after it is taken. It then drops, with `timeout_pulse` high for that one cycle only.
- R10: The holding master's releasing-type access to a different bank does not release the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one access per asserted cycle |
| acc_bank | input | BANK_W | Bank index of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_master | input | MASTER_W | ID of the accessing master |
| bank_mode | input | 2*NUM_BANKS | Atomic mode of each bank, two bits per bank |
| lock_active | output | 1 | Bus lock is held |
| lock_owner | output | MASTER_W | Master holding the lock |
| timeout_pulse | output | 1 | One-cycle pulse when the watchdog forces a release |
| acc_blocked | output | 1 | Previous access came from a non-owner while locked |
| mode_error | output | 1 | Previous access hit a reserved-mode bank |

## Verification
The bench checks that a release needs all three of the same master, the same bank and the opposite access type.
- A design that compared only the master would release on the holding master's access to another bank.
- A design that ignored the owner would let a blocked master unlock the bus.

It holds a lock through the whole watchdog window while the owner repeats its locking access partway through. A counter that restarted on that access would keep the lock well past cycle 256. An off-by-one count would drop the lock a cycle early or late. Mode 00 and mode 11 accesses are also sent with no lock held, to catch a decoder that treats the reserved code as a locking mode.

// File: rtl/atomic_lock_pkg.sv
package atomic_lock_pkg;
  typedef enum logic [1:0] {
    AMODE_NONE = 2'b00,
    AMODE_RAW  = 2'b01,
    AMODE_WAR  = 2'b10,
    AMODE_RSVD = 2'b11
  } amode_e;
endpackage

// File: rtl/atomic_mode_decode.sv
module atomic_mode_decode
  import atomic_lock_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [2*NUM_BANKS-1:0] bank_mode_i,
  input  logic [BANK_W-1:0]      bank_i,
  input  logic                   valid_i,
  input  logic                   write_i,
  output logic                   take_o,
  output logic                   take_relwr_o,
  output logic                   err_o
);
  amode_e mode;

  always_comb begin
    mode = amode_e'(bank_mode_i[{bank_i, 1'b0} +: 2]);
    take_o       = 1'b0;
    take_relwr_o = 1'b0;
    err_o        = 1'b0;
    if (valid_i) begin
      unique case (mode)
        AMODE_RAW:  take_o = write_i;
        AMODE_WAR: begin
          take_o       = ~write_i;
          take_relwr_o = 1'b1;
        end
        AMODE_RSVD: err_o = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/atomic_lock_timer.sv
module atomic_lock_timer #(
  parameter int TIMEOUT = 256,
  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/atomic_lock_ctrl.sv
module atomic_lock_ctrl #(
  parameter int NUM_BANKS = 8,
  parameter int MASTER_W  = 3,
  parameter int TIMEOUT   = 256,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic [BANK_W-1:0]      acc_bank,
  input  logic                   acc_write,
  input  logic [MASTER_W-1:0]    acc_master,
  input  logic [2*NUM_BANKS-1:0] bank_mode,
  output logic                   lock_active,
  output logic [MASTER_W-1:0]    lock_owner,
  output logic                   timeout_pulse,
  output logic                   acc_blocked,
  output logic                   mode_error
);
  logic                locked_q, relwr_q, blocked_q, err_q, tmo_q;
  logic [MASTER_W-1:0] owner_q;
  logic [BANK_W-1:0]   bank_q;
  logic take_req, take_relwr, err_req, expire;
  logic is_owner, release_now, force_now, take_now;

  atomic_mode_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
    .bank_mode_i (bank_mode),
    .bank_i      (acc_bank),
    .valid_i     (acc_valid),
    .write_i     (acc_write),
    .take_o      (take_req),
    .take_relwr_o(take_relwr),
    .err_o       (err_req)
  );

  assign is_owner    = locked_q && (acc_master == owner_q);
  assign release_now = acc_valid && is_owner && (acc_bank == bank_q) &&
                       (acc_write == relwr_q);
  assign force_now   = expire && !release_now;
  assign take_now    = !locked_q && take_req;

  atomic_lock_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear_i (take_now || release_now || force_now),
    .run_i   (locked_q),
    .expire_o(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q  <= 1'b0;
      relwr_q   <= 1'b0;
      owner_q   <= '0;
      bank_q    <= '0;
      blocked_q <= 1'b0;
      err_q     <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      blocked_q <= acc_valid && locked_q && !is_owner;
      err_q     <= err_req;
      tmo_q     <= force_now;
      if (take_now) begin
        locked_q <= 1'b1;
        relwr_q  <= take_relwr;
        owner_q  <= acc_master;
        bank_q   <= acc_bank;
      end else if (release_now || force_now) begin
        locked_q <= 1'b0;
        owner_q  <= '0;
      end
    end
  end

  assign lock_active   = locked_q;
  assign lock_owner    = owner_q;
  assign timeout_pulse = tmo_q;
  assign acc_blocked   = blocked_q;
  assign mode_error    = err_q;
endmodule

// File: rtl/atomic_lock_chk.sv
module atomic_lock_chk #(
  parameter int NUM_BANKS = 8,
  parameter int MASTER_W  = 3,
  parameter int TIMEOUT   = 256,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int RUN_W  = $clog2(TIMEOUT + 2) + 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   acc_valid,
  input logic [BANK_W-1:0]      acc_bank,
  input logic                   acc_write,
  input logic [MASTER_W-1:0]    acc_master,
  input logic [2*NUM_BANKS-1:0] bank_mode,
  input logic                   lock_active,
  input logic [MASTER_W-1:0]    lock_owner,
  input logic                   timeout_pulse,
  input logic                   acc_blocked,
  input logic                   mode_error
);
  logic [1:0]       mode;
  logic [RUN_W-1:0] run_cnt;
  assign mode = bank_mode[{acc_bank, 1'b0} +: 2];

  always_ff @(posedge clk) begin
    if (rst || !lock_active) run_cnt <= '0;
    else                     run_cnt <= run_cnt + 1'b1;
  end

  p_take_raw_r2: assert property (@(posedge clk) disable iff (rst)
    (!lock_active && acc_valid && mode == 2'b01 && acc_write) |=>
      (lock_active && lock_owner == $past(acc_master)));

  p_take_war_r4: assert property (@(posedge clk) disable iff (rst)
    (!lock_active && acc_valid && mode == 2'b10 && !acc_write) |=>
      (lock_active && lock_owner == $past(acc_master)));

  p_inert_r5: assert property (@(posedge clk) disable iff (rst)
    (!lock_active && acc_valid && mode[1] == mode[0]) |=> !lock_active);

  p_rsvd_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && mode == 2'b11) |=> mode_error);

  p_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (lock_active && acc_valid && acc_master != lock_owner) |=> acc_blocked);

  p_owner_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (lock_active && $past(lock_active)) |-> $stable(lock_owner));

  p_window_r9: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= RUN_W'(TIMEOUT));

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |=> !timeout_pulse);

  p_pulse_unlocked_r9: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |-> (!lock_active && $fell(lock_active)));
endmodule

bind atomic_lock_ctrl atomic_lock_chk #(
  .NUM_BANKS(NUM_BANKS), .MASTER_W(MASTER_W), .TIMEOUT(TIMEOUT)
) u_atomic_lock_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_bank(acc_bank),
  .acc_write(acc_write), .acc_master(acc_master), .bank_mode(bank_mode),
  .lock_active(lock_active), .lock_owner(lock_owner),
  .timeout_pulse(timeout_pulse), .acc_blocked(acc_blocked),
  .mode_error(mode_error)
);

// File: tb/test_atomic_lock_ctrl.sv
`timescale 1ns/1ps
module test_atomic_lock_ctrl;
  localparam int NB = 8;
  localparam int MW = 3;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [BW-1:0] acc_bank = '0;
  logic acc_write = 1'b0;
  logic [MW-1:0] acc_master = '0;
  logic [2*NB-1:0] bank_mode;
  logic lock_active, timeout_pulse, acc_blocked, mode_error;
  logic [MW-1:0] lock_owner;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  atomic_lock_ctrl #(.NUM_BANKS(NB), .MASTER_W(MW), .TIMEOUT(256)) i_atomic_lock_ctrl (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_bank(acc_bank),
    .acc_write(acc_write), .acc_master(acc_master), .bank_mode(bank_mode),
    .lock_active(lock_active), .lock_owner(lock_owner),
    .timeout_pulse(timeout_pulse), .acc_blocked(acc_blocked),
    .mode_error(mode_error)
  );

  // bank0=00 bank1=01 bank2=10 bank3=11 bank4=01 others 00
  initial begin
    bank_mode = '0;
    bank_mode[3:2] = 2'b01;
    bank_mode[5:4] = 2'b10;
    bank_mode[7:6] = 2'b11;
    bank_mode[9:8] = 2'b01;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one access; returns just after the edge that samples it.
  task automatic access(input int bank, input bit wr, input int m);
    @(negedge clk);
    acc_valid  = 1'b1;
    acc_bank   = BW'(bank);
    acc_write  = wr;
    acc_master = MW'(m);
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    idle(3);
    check("R1 lock_active", int'(lock_active), 0);
    check("R1 lock_owner", int'(lock_owner), 0);
    check("R1 timeout_pulse", int'(timeout_pulse), 0);
    check("R1 acc_blocked", int'(acc_blocked), 0);
    check("R1 mode_error", int'(mode_error), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_raw;
    access(1, 1'b0, 2);
    check("R2 read does not lock mode01", int'(lock_active), 0);
    access(1, 1'b1, 5);
    check("R2 write locks", int'(lock_active), 1);
    check("R2 owner", int'(lock_owner), 5);
    access(4, 1'b0, 5);
    check("R10 read other bank keeps lock", int'(lock_active), 1);
    access(1, 1'b0, 5);
    check("R3 owner read releases", int'(lock_active), 0);
    check("R3 no timeout pulse", int'(timeout_pulse), 0);
  endtask

  task automatic t_war;
    access(2, 1'b1, 3);
    check("R4 write does not lock mode10", int'(lock_active), 0);
    access(2, 1'b0, 3);
    check("R4 read locks", int'(lock_active), 1);
    check("R4 owner", int'(lock_owner), 3);
    access(2, 1'b0, 3);
    check("R4 repeat read keeps lock", int'(lock_active), 1);
    access(2, 1'b1, 3);
    check("R4 owner write releases", int'(lock_active), 0);
  endtask

  task automatic t_mode0;
    access(0, 1'b1, 1);
    check("R5 mode00 write no lock", int'(lock_active), 0);
    access(0, 1'b0, 1);
    check("R5 mode00 read no lock", int'(lock_active), 0);
    access(1, 1'b1, 1);
    access(0, 1'b0, 1);
    check("R5 mode00 access no release", int'(lock_active), 1);
    access(1, 1'b0, 1);
    check("R5 cleanup release", int'(lock_active), 0);
  endtask

  task automatic t_mode11;
    access(3, 1'b1, 4);
    check("R6 mode11 error", int'(mode_error), 1);
    check("R6 mode11 no lock", int'(lock_active), 0);
    access(3, 1'b0, 4);
    check("R6 mode11 read error", int'(mode_error), 1);
    check("R6 mode11 read no lock", int'(lock_active), 0);
    idle(1);
    check("R6 error one cycle", int'(mode_error), 0);
  endtask

  task automatic t_other;
    access(1, 1'b1, 2);
    access(1, 1'b0, 6);
    check("R7 other read no release", int'(lock_active), 1);
    check("R7 blocked", int'(acc_blocked), 1);
    check("R7 owner kept", int'(lock_owner), 2);
    access(4, 1'b1, 6);
    check("R7 other write no retake", int'(lock_owner), 2);
    check("R7 blocked again", int'(acc_blocked), 1);
    idle(1);
    check("R7 blocked one cycle", int'(acc_blocked), 0);
    access(1, 1'b0, 2);
    check("R7 cleanup release", int'(lock_active), 0);
  endtask

  task automatic t_timeout;
    int drops;
    access(1, 1'b1, 7);           // lock taken at edge E0
    idle(50);                     // E50
    access(1, 1'b1, 7);           // E51: repeat locking write
    check("R8 repeat keeps lock", int'(lock_active), 1);
    drops = 0;
    for (int i = 52; i <= 255; i++) begin
      @(posedge clk); #1;
      if (!lock_active) drops++;
    end
    check("R8 lock held through E255 (no restart)", drops, 0);
    check("R9 no pulse before expiry", int'(timeout_pulse), 0);
    idle(1);                      // E256
    check("R9 forced release", int'(lock_active), 0);
    check("R9 timeout pulse", int'(timeout_pulse), 1);
    idle(1);
    check("R9 pulse one cycle", int'(timeout_pulse), 0);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_raw();
    t_war();
    t_mode0();
    t_mode11();
    t_other();
    t_timeout();
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule